// File: doc/BRIEF.md
# Microwire Sequential Word Reader

This block is a bus master for a three-wire serial EEPROM (select, clock, data in each direction). It reads a run of consecutive 16-bit words. Software-side logic supplies a first address and a word count, then pulses a start input. For every word the reader opens its own chip-select transaction: a one-period select preamble, the read command, the address and then the returned bits. It then closes the transaction with a clocked deselect period before it moves on to the next address.

Each word that arrives is shown for one clock on a write-style port, together with its offset from the first address, so a local buffer can store it directly. A single done pulse marks the end of the run. The serial clock is derived from the system clock, with separate cycle counts for the low and high halves, so the minimum low and high times of slow parts can be met. The address width is a parameter, which covers both small (6-bit) and larger (8-bit) devices.

Top module: `mw_seq_reader`

## Requirements
- R1: After reset, and while no run is active, chip select, serial clock, word strobe and done are all low.
- R2: Each word transaction begins with chip select high for exactly one full serial clock period with data out low. The command bits 1, 1, 0 follow: a start bit, then a two-bit opcode equal to binary 10.
- R3: After the opcode, the address is sent MSB first in ADDR_W bits. Word i of a run uses address (first address + i) modulo 2^ADDR_W.
- R4: After the address, the reader gives 17 serial clock periods and samples data in at the end of each low half. The first sample is a dummy and is dropped. The other 16 form the word, MSB first.
- R5: Each word is presented with a strobe that is high for one cycle while chip select is still high. The word index port equals the word's position in the run, starting at 0.
- R6: Between two words of a run, chip select is low for at least one full serial clock period that includes a rising clock edge.
- R7: Done is a one-cycle pulse that follows the deselect period after the final word, with chip select low. A run of N words gives exactly N strobes and one done.
- R8: A start with a word count of 0 gives a done pulse on the next cycle and no chip-select activity.
- R9: A start request while a run is active is ignored. The run in progress completes unchanged.
- R10: Every serial clock low phase lasts at least LOW_CYC system cycles and every high phase at least HIGH_CYC. Data out and chip select change only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a run (ignored while busy) |
| startAddr | input | ADDR_W | First word address of the run |
| wordCount | input | ADDR_W+1 | Number of words to read (0 allowed) |
| csOut | output | 1 | Chip select to the EEPROM, active high |
| skOut | output | 1 | Serial clock to the EEPROM |
| mosiOut | output | 1 | Serial data toward the EEPROM |
| misoIn | input | 1 | Serial data from the EEPROM |
| wordValid | output | 1 | One-cycle strobe: wordData and wordIndex are valid |
| wordData | output | WORD_W | Received word |
| wordIndex | output | ADDR_W | Offset of the word from startAddr |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bound checker watches the serial clock phase lengths on every cycle, and also checks that data out and chip select hold steady through each high phase. It checks as well that the strobe and done are single-cycle pulses and that each appears with the right chip-select level. Command framing, address order, dropping the dummy bit, word contents and indices, the deselect gap and the handling of a start while busy can only be shown by the bench's scenarios. These run against a behavioural EEPROM and include an address wrap and a zero-length run.

// File: rtl/mw_reader_pkg.sv
package mw_reader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_DESEL
  } rdState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic run;      // serial clock divider active
    logic load;     // capture first address and count
    logic sample;   // shift data in this cycle
    logic wordEnd;  // final sample of a word
    logic advance;  // step to next address after deselect
  } rdStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic lowEnd;     // last cycle of a low half
    logic periodEnd;  // last cycle of a high half
    logic lastWord;   // current word is the final one
    logic countZero;  // requested count is zero
  } rdStatus_t;

  localparam int CMD_LEN = 3;
  localparam logic [CMD_LEN-1:0] READ_CMD = 3'b110;

endpackage

// File: rtl/mw_reader_dp.sv
module mw_reader_dp
  import mw_reader_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int WORD_W   = 16,
  parameter int LOW_CYC  = 64,
  parameter int HIGH_CYC = 192
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W:0]   wordCount,
  input  logic              misoIn,
  output rdStatus_t         stat,
  output logic [ADDR_W-1:0] curAddr,
  output logic              skOut,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordIndex
);

  localparam int CNT_W   = ADDR_W + 1;
  localparam int DIV_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam logic [DIV_W-1:0] LOW_LAST  = DIV_W'(LOW_CYC - 1);
  localparam logic [DIV_W-1:0] HIGH_LAST = DIV_W'(HIGH_CYC - 1);

  logic [DIV_W-1:0]  divCnt;
  logic              skReg;
  logic              lowDone;
  logic              highDone;
  logic [CNT_W-1:0]  remaining;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] idxReg;
  logic [WORD_W-1:0] shiftReg;
  logic              validReg;

  assign lowDone  = !skReg && (divCnt == LOW_LAST);
  assign highDone = skReg && (divCnt == HIGH_LAST);

  // serial clock generator: low half then high half per period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      skReg  <= 1'b0;
    end else if (!strobe.run) begin
      divCnt <= '0;
      skReg  <= 1'b0;
    end else if (lowDone || highDone) begin
      divCnt <= '0;
      skReg  <= !skReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // run bookkeeping: address, words left, index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      remaining <= '0;
      idxReg    <= '0;
    end else if (strobe.load) begin
      addrReg   <= startAddr;
      remaining <= wordCount;
      idxReg    <= '0;
    end else if (strobe.advance) begin
      addrReg   <= addrReg + 1'b1;
      remaining <= remaining - 1'b1;
      idxReg    <= idxReg + 1'b1;
    end
  end

  // receive shifter: all 17 samples pass through, the dummy falls off the top
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= strobe.wordEnd;
      if (strobe.sample) begin
        shiftReg <= {shiftReg[WORD_W-2:0], misoIn};
      end
    end
  end

  assign stat.lowEnd    = strobe.run && lowDone;
  assign stat.periodEnd = strobe.run && highDone;
  assign stat.lastWord  = (remaining == CNT_W'(1));
  assign stat.countZero = (wordCount == '0);

  assign curAddr   = addrReg;
  assign skOut     = skReg;
  assign wordValid = validReg;
  assign wordData  = shiftReg;
  assign wordIndex = idxReg;

endmodule

// File: rtl/mw_reader_ctrl.sv
module mw_reader_ctrl
  import mw_reader_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  rdStatus_t         stat,
  input  logic [ADDR_W-1:0] curAddr,
  output rdStrobe_t         strobe,
  output logic              csOut,
  output logic              mosiOut,
  output logic              done
);

  localparam int DATA_LEN = WORD_W + 1;
  localparam int BIT_W    = $clog2(DATA_LEN + 1);
  localparam logic [BIT_W-1:0] CMD_LAST  = BIT_W'(CMD_LEN - 1);
  localparam logic [BIT_W-1:0] ADDR_LAST = BIT_W'(ADDR_W - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_LEN - 1);

  rdState_t          state, stateNext;
  logic [BIT_W-1:0]  bitCnt, bitCntNext;
  logic              doneReg;
  logic              isIdle;
  logic [CMD_LEN-1:0] cmdShifted;
  logic [ADDR_W-1:0] addrShifted;

  assign isIdle = (state == ST_IDLE);

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    unique case (state)
      ST_IDLE: begin
        if (startReq && !stat.countZero) begin
          stateNext  = ST_SEL;
          bitCntNext = '0;
        end
      end
      ST_SEL: begin
        if (stat.periodEnd) begin
          stateNext  = ST_CMD;
          bitCntNext = '0;
        end
      end
      ST_CMD: begin
        if (stat.periodEnd) begin
          if (bitCnt == CMD_LAST) begin
            stateNext  = ST_ADDR;
            bitCntNext = '0;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
      end
      ST_ADDR: begin
        if (stat.periodEnd) begin
          if (bitCnt == ADDR_LAST) begin
            stateNext  = ST_DATA;
            bitCntNext = '0;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (stat.periodEnd) begin
          if (bitCnt == DATA_LAST) begin
            stateNext  = ST_DESEL;
            bitCntNext = '0;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end
      end
      ST_DESEL: begin
        if (stat.periodEnd) begin
          stateNext  = stat.lastWord ? ST_IDLE : ST_SEL;
          bitCntNext = '0;
        end
      end
      default: begin
        stateNext  = ST_IDLE;
        bitCntNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      bitCnt  <= bitCntNext;
      doneReg <= (isIdle && startReq && stat.countZero) ||
                 (strobe.advance && stat.lastWord);
    end
  end

  assign strobe.run     = !isIdle;
  assign strobe.load    = isIdle && startReq && !stat.countZero;
  assign strobe.sample  = (state == ST_DATA) && stat.lowEnd;
  assign strobe.wordEnd = strobe.sample && (bitCnt == DATA_LAST);
  assign strobe.advance = (state == ST_DESEL) && stat.periodEnd;

  // outgoing bit: MSB of the remaining command or address bits
  assign cmdShifted  = READ_CMD << bitCnt;
  assign addrShifted = curAddr << bitCnt;

  always_comb begin
    unique case (state)
      ST_CMD:  mosiOut = cmdShifted[CMD_LEN-1];
      ST_ADDR: mosiOut = addrShifted[ADDR_W-1];
      default: mosiOut = 1'b0;
    endcase
  end

  assign csOut = !(isIdle || (state == ST_DESEL));
  assign done  = doneReg;

endmodule

// File: rtl/mw_seq_reader.sv
module mw_seq_reader
  import mw_reader_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int WORD_W   = 16,
  parameter int LOW_CYC  = 64,
  parameter int HIGH_CYC = 192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W:0]   wordCount,
  output logic              csOut,
  output logic              skOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordIndex,
  output logic              done
);

  rdStrobe_t         strobe;
  rdStatus_t         stat;
  logic [ADDR_W-1:0] curAddr;

  mw_reader_ctrl #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .stat    (stat),
    .curAddr (curAddr),
    .strobe  (strobe),
    .csOut   (csOut),
    .mosiOut (mosiOut),
    .done    (done)
  );

  mw_reader_dp #(
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startAddr(startAddr),
    .wordCount(wordCount),
    .misoIn   (misoIn),
    .stat     (stat),
    .curAddr  (curAddr),
    .skOut    (skOut),
    .wordValid(wordValid),
    .wordData (wordData),
    .wordIndex(wordIndex)
  );

endmodule

// File: rtl/mw_reader_chk.sv
module mw_reader_chk #(
  parameter int LOW_CYC  = 64,
  parameter int HIGH_CYC = 192
) (
  input logic clk,
  input logic rstN,
  input logic csOut,
  input logic skOut,
  input logic mosiOut,
  input logic wordValid,
  input logic done
);

  logic [15:0] hiCnt;
  logic [15:0] loCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else if (skOut) begin
      hiCnt <= (hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 16'd1;
      loCnt <= '0;
    end else begin
      loCnt <= (loCnt == 16'hFFFF) ? loCnt : loCnt + 16'd1;
      hiCnt <= '0;
    end
  end

  // R10: phase lengths
  p_high_min_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(skOut) |-> (hiCnt >= 16'(HIGH_CYC)));
  p_low_min_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(skOut) |-> (loCnt >= 16'(LOW_CYC)));

  // R10: outputs hold while clock is high
  p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (skOut && $past(skOut)) |-> $stable(mosiOut));
  p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (skOut && $past(skOut)) |-> $stable(csOut));

  // R5: strobe is one cycle and inside the transaction
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  p_valid_in_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> csOut);

  // R7: done is one cycle and follows deselect
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_cs_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !csOut);

endmodule

bind mw_seq_reader mw_reader_chk #(
  .LOW_CYC (LOW_CYC),
  .HIGH_CYC(HIGH_CYC)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .csOut    (csOut),
  .skOut    (skOut),
  .mosiOut  (mosiOut),
  .wordValid(wordValid),
  .done     (done)
);

// File: tb/mw_seq_reader_test.sv
`timescale 1ns/1ps
module mw_seq_reader_test;
  localparam int ADDR_W   = 6;
  localparam int WORD_W   = 16;
  localparam int LOW_CYC  = 2;
  localparam int HIGH_CYC = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [ADDR_W:0]   wordCount = '0;
  logic              csOut, skOut, mosiOut;
  logic              misoIn = 1'b0;
  logic              wordValid, done;
  logic [WORD_W-1:0] wordData;
  logic [ADDR_W-1:0] wordIndex;

  mw_seq_reader #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .wordCount(wordCount), .csOut(csOut), .skOut(skOut), .mosiOut(mosiOut),
    .misoIn(misoIn), .wordValid(wordValid), .wordData(wordData),
    .wordIndex(wordIndex), .done(done)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [15:0] memFn(input logic [ADDR_W-1:0] a);
    logic [15:0] x;
    x = {10'b0, a};
    return (x * 16'h03B9 + 16'h8C15) ^ {a, a[2:0], ~a, 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural EEPROM
  int txN = 0;
  logic [ADDR_W-1:0] txAddr [0:255];
  logic [1:0]        txOp   [0:255];
  int                txLead [0:255];
  int                txDesel[0:255];
  int   lead = 0, deselRun = 0, got = 0, bitPtr = 0;
  logic started = 1'b0, sending = 1'b0;
  logic [ADDR_W+1:0] hdr = '0;
  logic [15:0] outWord = '0;

  always @(posedge skOut) begin
    if (!csOut) begin
      deselRun++;
    end else if (!started) begin
      if (mosiOut) begin
        started = 1'b1; got = 0; hdr = '0;
      end else begin
        lead++;
      end
    end else if (!sending) begin
      hdr = {hdr[ADDR_W:0], mosiOut};
      got++;
      if (got == ADDR_W + 2) begin
        sending = 1'b1;
        misoIn  = 1'b0;
        outWord = memFn(hdr[ADDR_W-1:0]);
        bitPtr  = 16;
        txAddr[txN & 255] = hdr[ADDR_W-1:0];
        txOp[txN & 255]   = hdr[ADDR_W+1:ADDR_W];
        txLead[txN & 255] = lead;
        txN++;
      end
    end else begin
      if (bitPtr > 0) begin
        misoIn = outWord[bitPtr-1];
        bitPtr--;
      end else begin
        misoIn = 1'b0;
      end
    end
  end

  always @(posedge csOut) begin
    started = 1'b0; sending = 1'b0; lead = 0;
    txDesel[txN & 255] = deselRun;
    deselRun = 0;
  end

  always @(negedge csOut) misoIn = 1'b0;

  // output monitor
  logic [WORD_W-1:0] capData[0:255];
  logic [ADDR_W-1:0] capIdx [0:255];
  int capN = 0, doneN = 0;
  int hiRun = 0, loRun = 0, minHigh = 1000, minLow = 1000;

  always @(negedge clk) begin
    if (rstN) begin
      if (wordValid) begin
        capData[capN & 255] = wordData;
        capIdx[capN & 255]  = wordIndex;
        capN++;
      end
      if (done) doneN++;
      if (skOut) begin
        if (loRun > 0 && loRun < minLow) minLow = loRun;
        loRun = 0; hiRun++;
      end else begin
        if (hiRun > 0 && hiRun < minHigh) minHigh = hiRun;
        hiRun = 0; loRun++;
      end
    end
  end

  task automatic runRead(input int sa, input int cnt, input bit pokeBusy);
    int txBase, capBase, doneBase, waitC;
    logic [ADDR_W-1:0] expAddr;
    txBase = txN; capBase = capN; doneBase = doneN; waitC = 0;
    @(negedge clk);
    startAddr = ADDR_W'(sa); wordCount = (ADDR_W+1)'(cnt); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (pokeBusy) begin
      repeat (40) @(negedge clk);
      startAddr = ADDR_W'(sa + 9); wordCount = 1; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (!done && waitC < 20000) begin
      @(negedge clk);
      waitC++;
    end
    check(done == 1'b1, "R7", "done seen", 32'(done), 1);
    check(csOut == 1'b0, "R7", "cs low at done", 32'(csOut), 0);
    check(deselRun >= 1, "R7", "deselect edges before done", 32'(deselRun), 1);
    repeat (30) @(negedge clk);
    check(doneN - doneBase == 1, "R7", "done pulses", 32'(doneN - doneBase), 1);
    check(capN - capBase == cnt, pokeBusy ? "R9" : "R5", "strobes",
          32'(capN - capBase), 32'(cnt));
    check(txN - txBase == cnt, pokeBusy ? "R9" : "R3", "transactions",
          32'(txN - txBase), 32'(cnt));
    for (int i = 0; i < cnt; i++) begin
      expAddr = ADDR_W'(sa + i);
      check(txAddr[(txBase+i) & 255] == expAddr, "R3", "address sent",
            32'(txAddr[(txBase+i) & 255]), 32'(expAddr));
      check(txOp[(txBase+i) & 255] == 2'b10, "R2", "opcode",
            32'(txOp[(txBase+i) & 255]), 32'h2);
      check(txLead[(txBase+i) & 255] == 1, "R2", "select preamble periods",
            32'(txLead[(txBase+i) & 255]), 1);
      check(capData[(capBase+i) & 255] == memFn(expAddr), "R4", "word data",
            32'(capData[(capBase+i) & 255]), 32'(memFn(expAddr)));
      check(capIdx[(capBase+i) & 255] == ADDR_W'(i), "R5", "word index",
            32'(capIdx[(capBase+i) & 255]), 32'(i));
      if (i > 0)
        check(txDesel[(txBase+i) & 255] >= 1, "R6", "deselect edges between words",
              32'(txDesel[(txBase+i) & 255]), 1);
    end
  endtask

  task automatic runZero(input int sa);
    int txBase, capBase;
    txBase = txN; capBase = capN;
    @(negedge clk);
    startAddr = ADDR_W'(sa); wordCount = '0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(done == 1'b1, "R8", "done next cycle", 32'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", 32'(done), 0);
    repeat (20) begin
      @(negedge clk);
      if (csOut) check(1'b0, "R8", "cs during empty run", 1, 0);
    end
    check(txN == txBase, "R8", "no transaction", 32'(txN - txBase), 0);
    check(capN == capBase, "R8", "no strobe", 32'(capN - capBase), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    check(csOut == 0 && skOut == 0, "R1", "cs/sk in reset", {csOut, skOut}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check({csOut, skOut, wordValid, done} == 4'b0, "R1", "idle outputs",
          32'({csOut, skOut, wordValid, done}), 0);

    runRead(5, 1, 1'b0);          // single word
    runRead(62, 4, 1'b0);         // wraps through top of address space
    runZero(17);                  // empty run
    runRead(20, 3, 1'b1);         // start while busy is ignored
    runRead(0, 2, 1'b0);
    for (int k = 0; k < 6; k++) begin
      runRead(int'($urandom % 64), 1 + int'($urandom % 4), 1'b0);
    end
    check(minHigh >= HIGH_CYC, "R10", "shortest high phase", 32'(minHigh), 32'(HIGH_CYC));
    check(minLow >= LOW_CYC, "R10", "shortest low phase", 32'(minLow), 32'(LOW_CYC));
    check({csOut, skOut} == 2'b0, "R1", "idle after runs", 32'({csOut, skOut}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule